// File: doc/BRIEF.md
# Processor Bus Burst Bridge

This block is a slave bridge between an external processor bus and an on-chip system bus. The processor opens a transaction with a one-cycle start strobe that carries an address, a direction and a burst flag. It then moves one beat per cycle in which it raises its data-valid strobe and the bridge answers with a transfer acknowledge. The processor data port is 8, 16 or 32 bits wide, set by a parameter. Burst length follows from the port width so that every burst moves 16 bytes: 16 beats of one byte, 8 beats of two bytes, or 4 beats of four bytes. A single transfer is one beat of the port width.

Two small word FIFOs sit between the sides so that each side can run at its own pace. Write beats are packed into 32-bit words in ascending byte-address order and drained to the internal bus. Read words fetched from the internal bus are unpacked into beats in the same order. The internal bus uses request/acknowledge: the bridge holds a word request stable until the target acknowledges it. An optional even parity bit per byte lane is generated on read data and checked on write data. A write mismatch raises a sticky error flag and the data is still forwarded.

Top module: `pbus_bridge`

## Requirements
- R1: After reset the bridge is idle: `cpu_busy`, `cpu_ta`, `ibus_req` and `cpu_perr` are all 0.
- R2: A burst moves exactly 16 bytes: 16/(DATA_W/8) acknowledged beats and four internal words at ascending word addresses. The first word address is the start address with its four low byte-address bits cleared.
- R3: Write beats are packed with the beat at the lower byte address in the lower-numbered byte lane. Lane n is `ibus_wdata[8n+7:8n]`. Burst words carry `ibus_be` = 4'b1111.
- R4: A single transfer is one beat mapped to word address `cpu_addr>>2`. Its byte lanes start at `cpu_addr[1:0]` rounded down to the beat size. On writes only those lanes are enabled in `ibus_be`. On reads the beat returns those lanes.
- R5: The write FIFO holds a complete 16-byte burst. Every write beat of a burst is acknowledged in the same cycle its data-valid is high, even while the internal bus never acknowledges.
- R6: A read beat is acknowledged only once its data is in the read FIFO. With a slow internal target, read beats wait.
- R7: Read words are unpacked into beats in ascending byte-address order, lowest lane first.
- R8: With parity enabled, `cpu_rpar[k]` is the XOR of the eight bits of read byte lane k (even parity).
- R9: A write beat whose parity bit differs from the XOR of its byte sets `cpu_perr` one cycle after its acknowledge. The flag stays set until reset, and the beat's data is still written.
- R10: An internal request that is not acknowledged stays asserted with unchanged address, direction and write data in the next cycle.
- R11: A start strobe while the bridge is busy is ignored and produces no internal access.
- R12: `cpu_ta` is only asserted while a transaction is open and `cpu_dv` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ts | input | 1 | Transaction start strobe |
| cpu_addr | input | ADDR_W | Byte address of the transaction |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_burst | input | 1 | 1 = 16-byte burst, 0 = single beat |
| cpu_dv | input | 1 | Processor offers or wants a beat this cycle |
| cpu_wdata | input | DATA_W | Write beat data |
| cpu_wpar | input | DATA_W/8 | Write parity, one bit per byte |
| cpu_ta | output | 1 | Transfer acknowledge for the current beat |
| cpu_rdata | output | DATA_W | Read beat data, valid with `cpu_ta` |
| cpu_rpar | output | DATA_W/8 | Read parity, one bit per byte |
| cpu_busy | output | 1 | A transaction is open or still draining |
| cpu_perr | output | 1 | Sticky write parity error |
| ibus_req | output | 1 | Internal word request |
| ibus_we | output | 1 | Internal request is a write |
| ibus_addr | output | ADDR_W-2 | Internal word address |
| ibus_wdata | output | 32 | Internal write word |
| ibus_be | output | 4 | Internal byte enables |
| ibus_ack | input | 1 | Internal acknowledge, completes the current request |
| ibus_rdata | input | 32 | Internal read word, valid with `ibus_ack` |

## Verification
The bench runs an 8-bit port, so a single burst crosses four word boundaries on both the packing and the unpacking paths. A lane or address slip would show up as a word mismatch on the internal bus, or as a wrong byte on read-back. The bench holds the internal target in a long stall during a write burst. A write FIFO that is too shallow would then hold off acknowledges, and a read path that acknowledges too early would hand back stale bytes. It sends a bad-parity beat and then a clean transaction, which catches a flag that is lost, that fires late, or that drops the data. It also raises a stray start strobe in the middle of a burst. A bridge that accepted it would issue internal words that nobody expects.

// File: rtl/pbus_bridge_pkg.sv
package pbus_bridge_pkg;

    localparam int WORD_W      = 32;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int BURST_BYTES = 16;
    localparam int BURST_WORDS = BURST_BYTES / WORD_BYTES;

    typedef struct packed {
        logic [WORD_W-1:0]     data;
        logic [WORD_BYTES-1:0] be;
    } word_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_t;

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/pbus_wr_fifo.sv
module pbus_wr_fifo
    import pbus_bridge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_push,
    input  logic [LW-1:0]     beat_lane,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              word_end,
    input  logic              pop,
    output word_t             head,
    output logic              full,
    output logic              avail
);
    localparam int BPB = DATA_W / 8;
    localparam int LANES = WORD_W / DATA_W;
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int PW = $clog2(DEPTH);

    word_t          mem [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [PW:0]    cnt;
    logic           commit;

    assign commit = beat_push && word_end;
    assign full   = (cnt == (PW+1)'(DEPTH));
    assign avail  = (cnt != '0);
    assign head   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (beat_push) begin
                mem[wp].data[int'(beat_lane)*DATA_W +: DATA_W] <= beat_data;
                mem[wp].be[int'(beat_lane)*BPB +: BPB]         <= '1;
            end
            if (commit) wp <= wp + 1'b1;
            if (pop) begin
                mem[rp].be <= '0;
                rp         <= rp + 1'b1;
            end
            cnt <= cnt + (PW+1)'(commit) - (PW+1)'(pop);
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        beat_push |-> !full);
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
        pop |-> avail);

endmodule

// File: rtl/pbus_rd_fifo.sv
module pbus_rd_fifo
    import pbus_bridge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              beat_pop,
    input  logic [LW-1:0]     beat_lane,
    input  logic              word_end,
    output logic [DATA_W-1:0] head_beat,
    output logic              avail,
    output logic              space
);
    localparam int LANES = WORD_W / DATA_W;
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int PW = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic [PW:0]       cnt;
    logic              release_word;

    assign release_word = beat_pop && word_end;
    assign avail        = (cnt != '0);
    assign space        = (cnt < (PW+1)'(DEPTH));
    assign head_beat    = mem[rp][int'(beat_lane)*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wp] <= push_word;
                wp      <= wp + 1'b1;
            end
            if (release_word) rp <= rp + 1'b1;
            cnt <= cnt + (PW+1)'(push) - (PW+1)'(release_word);
        end
    end

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        beat_pop |-> avail);
    p_push_room_r6: assert property (@(posedge clk) disable iff (rst)
        push |-> space);

endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
    import pbus_bridge_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 24,
    parameter bit PAR_EN     = 1'b1,
    parameter int FIFO_WORDS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_ts,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rnw,
    input  logic                cpu_burst,
    input  logic                cpu_dv,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic [DATA_W/8-1:0] cpu_wpar,
    output logic                cpu_ta,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic [DATA_W/8-1:0] cpu_rpar,
    output logic                cpu_busy,
    output logic                cpu_perr,
    output logic                ibus_req,
    output logic                ibus_we,
    output logic [ADDR_W-3:0]   ibus_addr,
    output logic [WORD_W-1:0]   ibus_wdata,
    output logic [3:0]          ibus_be,
    input  logic                ibus_ack,
    input  logic [WORD_W-1:0]   ibus_rdata
);
    localparam int BPB         = DATA_W / 8;
    localparam int LANES       = WORD_W / DATA_W;
    localparam int LW          = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int BURST_BEATS = BURST_BYTES / BPB;
    localparam int BCW         = $clog2(BURST_BEATS + 1);
    localparam int WCW         = $clog2(BURST_WORDS + 1);
    localparam int SHIFT       = $clog2(BPB);

    state_t            state;
    logic              t_rnw, t_burst;
    logic [ADDR_W-3:0] t_word;
    logic [LW-1:0]     t_lane0, cur_lane;
    logic [BCW-1:0]    beats_done, beats_total;
    logic [WCW-1:0]    words_done, words_total;
    logic              beats_left, words_left, word_end;
    logic              wf_full, wf_avail, rf_avail, rf_space;
    logic              xfer_ok, wr_beat, rd_beat, ibus_done;
    logic [BPB-1:0]    wpar_calc;
    word_t             wf_head;

    assign beats_total = t_burst ? BCW'(BURST_BEATS) : BCW'(1);
    assign words_total = t_burst ? WCW'(BURST_WORDS) : WCW'(1);
    assign beats_left  = (beats_done != beats_total);
    assign words_left  = (words_done != words_total);
    assign cpu_busy    = (state == ST_BUSY);

    always_comb begin
        if (LANES == 1) cur_lane = '0;
        else            cur_lane = LW'(t_lane0 + LW'(beats_done));
    end
    assign word_end = !t_burst || (cur_lane == LW'(LANES - 1));

    // processor side
    assign xfer_ok = t_rnw ? rf_avail : !wf_full;
    assign cpu_ta  = cpu_busy && beats_left && cpu_dv && xfer_ok;
    assign wr_beat = cpu_ta && !t_rnw;
    assign rd_beat = cpu_ta && t_rnw;

    // internal side
    assign ibus_req   = cpu_busy && words_left && (t_rnw ? rf_space : wf_avail);
    assign ibus_we    = !t_rnw;
    assign ibus_addr  = t_word + (ADDR_W-2)'(words_done);
    assign ibus_wdata = wf_head.data;
    assign ibus_be    = t_rnw ? 4'b1111 : wf_head.be;
    assign ibus_done  = ibus_req && ibus_ack;

    // parity
    generate
        for (genvar g = 0; g < BPB; g++) begin : g_par
            assign wpar_calc[g] = even_par(cpu_wdata[8*g +: 8]);
            assign cpu_rpar[g]  = PAR_EN ? even_par(cpu_rdata[8*g +: 8]) : 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            t_rnw      <= 1'b0;
            t_burst    <= 1'b0;
            t_word     <= '0;
            t_lane0    <= '0;
            beats_done <= '0;
            words_done <= '0;
            cpu_perr   <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                if (cpu_ts) begin
                    state      <= ST_BUSY;
                    t_rnw      <= cpu_rnw;
                    t_burst    <= cpu_burst;
                    beats_done <= '0;
                    words_done <= '0;
                    if (cpu_burst) begin
                        t_word  <= {cpu_addr[ADDR_W-1:4], 2'b00};
                        t_lane0 <= '0;
                    end else begin
                        t_word  <= cpu_addr[ADDR_W-1:2];
                        t_lane0 <= LW'(cpu_addr[1:0] >> SHIFT);
                    end
                end
            end else begin
                if (cpu_ta)    beats_done <= beats_done + 1'b1;
                if (ibus_done) words_done <= words_done + 1'b1;
                if (!beats_left && !words_left) state <= ST_IDLE;
            end
            if (PAR_EN && wr_beat && (wpar_calc != cpu_wpar)) cpu_perr <= 1'b1;
        end
    end

    pbus_wr_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_WORDS)) u_wr_fifo (
        .clk       (clk),
        .rst       (rst),
        .beat_push (wr_beat),
        .beat_lane (cur_lane),
        .beat_data (cpu_wdata),
        .word_end  (word_end),
        .pop       (ibus_done && !t_rnw),
        .head      (wf_head),
        .full      (wf_full),
        .avail     (wf_avail)
    );

    pbus_rd_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_WORDS)) u_rd_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (ibus_done && t_rnw),
        .push_word (ibus_rdata),
        .beat_pop  (rd_beat),
        .beat_lane (cur_lane),
        .word_end  (word_end),
        .head_beat (cpu_rdata),
        .avail     (rf_avail),
        .space     (rf_space)
    );

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ibus_req && !ibus_ack |=> ibus_req && $stable(ibus_addr)
                                 && $stable(ibus_we) && $stable(ibus_wdata));
    p_perr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_perr |=> cpu_perr);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !cpu_busy |-> !ibus_req && !cpu_ta);
    p_word_limit_r2: assert property (@(posedge clk) disable iff (rst)
        ibus_done |-> words_done < words_total);
    p_beat_limit_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_ta |-> beats_done < beats_total);

endmodule

// File: tb/pbus_bridge_tb.sv
`timescale 1ns/1ps
module pbus_bridge_tb;
    localparam int DW = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_ts, cpu_rnw, cpu_burst, cpu_dv;
    logic [AW-1:0] cpu_addr;
    logic [7:0]    cpu_wdata;
    logic [0:0]    cpu_wpar;
    logic          cpu_ta, cpu_busy, cpu_perr;
    logic [7:0]    cpu_rdata;
    logic [0:0]    cpu_rpar;
    logic          ibus_req, ibus_we, ibus_ack;
    logic [AW-3:0] ibus_addr;
    logic [31:0]   ibus_wdata, ibus_rdata;
    logic [3:0]    ibus_be;

    always #10 clk = ~clk;

    pbus_bridge #(.DATA_W(DW), .ADDR_W(AW), .PAR_EN(1'b1), .FIFO_WORDS(4)) u_dut (
        .clk(clk), .rst(rst), .cpu_ts(cpu_ts), .cpu_addr(cpu_addr),
        .cpu_rnw(cpu_rnw), .cpu_burst(cpu_burst), .cpu_dv(cpu_dv),
        .cpu_wdata(cpu_wdata), .cpu_wpar(cpu_wpar), .cpu_ta(cpu_ta),
        .cpu_rdata(cpu_rdata), .cpu_rpar(cpu_rpar), .cpu_busy(cpu_busy),
        .cpu_perr(cpu_perr), .ibus_req(ibus_req), .ibus_we(ibus_we),
        .ibus_addr(ibus_addr), .ibus_wdata(ibus_wdata), .ibus_be(ibus_be),
        .ibus_ack(ibus_ack), .ibus_rdata(ibus_rdata)
    );

    int checks = 0;
    int errors = 0;
    int stall  = 0;
    bit rd_mode = 1'b0;
    logic [31:0] mem [64];
    logic [7:0]  wbuf [16];
    logic [49:0] exp_w [$];
    logic [7:0]  exp_r [$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // internal target model and write scoreboard
    int wcnt = 0;
    always @(negedge clk) begin
        ibus_ack = 1'b0;
        if (!rst && ibus_req) begin
            if (wcnt >= stall) begin
                wcnt = 0;
                ibus_ack = 1'b1;
                ibus_rdata = mem[ibus_addr[5:0]];
                if (ibus_we) begin
                    if (exp_w.size() == 0) begin
                        chk(0, "R11 unexpected internal word", {ibus_addr, ibus_wdata, ibus_be}, 0);
                    end else begin
                        logic [49:0] e;
                        logic ok;
                        e = exp_w.pop_front();
                        ok = (ibus_addr == e[49:36]) && (ibus_be == e[3:0]);
                        for (int n = 0; n < 4; n++)
                            if (e[n] && ibus_wdata[8*n +: 8] != e[4+8*n +: 8]) ok = 0;
                        chk(ok, "R2/R3/R4 write word", {ibus_addr, ibus_wdata, ibus_be}, e);
                    end
                    for (int n = 0; n < 4; n++)
                        if (ibus_be[n]) mem[ibus_addr[5:0]][8*n +: 8] = ibus_wdata[8*n +: 8];
                end
            end else begin
                wcnt++;
            end
        end
    end

    // read beat monitor
    always @(negedge clk) begin
        #2;
        if (rd_mode && cpu_ta) begin
            logic [7:0] e;
            if (exp_r.size() == 0) begin
                chk(0, "R7 extra read beat", cpu_rdata, 0);
            end else begin
                e = exp_r.pop_front();
                chk(cpu_rdata == e, "R7/R4 read beat", cpu_rdata, e);
                chk(cpu_rpar[0] == ^e, "R8 read parity", cpu_rpar, ^e);
            end
        end
    end

    int nack;

    task automatic run_txn(input logic [AW-1:0] a, input bit rnw, input bit burst,
                           input int bad, input bit stray);
        int n = burst ? 16 : 1;
        int k = 0;
        nack = 0;
        while (cpu_busy) @(negedge clk);
        @(negedge clk);
        rd_mode = rnw;
        cpu_ts = 1; cpu_addr = a; cpu_rnw = rnw; cpu_burst = burst;
        @(negedge clk);
        cpu_ts = 0;
        while (k < n) begin
            @(negedge clk);
            cpu_ts = (stray && k == 5);
            if (cpu_ts) begin cpu_addr = 16'h0300; cpu_rnw = 1; cpu_burst = 1; end
            cpu_dv = 1;
            cpu_wdata = wbuf[k];
            cpu_wpar = ^wbuf[k] ^ (k == bad);
            #1;
            if (cpu_ta) k++;
            else nack++;
        end
        @(negedge clk);
        cpu_dv = 0; cpu_ts = 0;
        while (cpu_busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE0000 + i;
        for (int i = 0; i < 16; i++) wbuf[i] = 8'h11 + 8'(i * 7);
        rst = 1; cpu_ts = 0; cpu_addr = 0; cpu_rnw = 0; cpu_burst = 0;
        cpu_dv = 0; cpu_wdata = 0; cpu_wpar = 0; ibus_ack = 0; ibus_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        chk(!cpu_busy && !cpu_ta && !ibus_req && !cpu_perr, "R1 reset state",
            {cpu_busy, cpu_ta, ibus_req, cpu_perr}, 0);
        cpu_dv = 1; #1;
        chk(!cpu_ta, "R12 no ack while idle", cpu_ta, 0);
        cpu_dv = 0;

        // R5 + R2 + R3: burst write with a stalled target, low address bits ignored
        stall = 20;
        for (int w = 0; w < 4; w++)
            exp_w.push_back({14'(16 + w), wbuf[4*w+3], wbuf[4*w+2], wbuf[4*w+1], wbuf[4*w], 4'hF});
        run_txn(16'h0045, 0, 1, -1, 0);
        chk(nack == 0, "R5 burst beats without stall", nack, 0);
        chk(exp_w.size() == 0, "R2 four words written", exp_w.size(), 0);

        // R6 + R7: read the burst back with a slow target
        stall = 5;
        for (int i = 0; i < 16; i++) exp_r.push_back(wbuf[i]);
        run_txn(16'h0040, 1, 1, -1, 0);
        chk(nack >= 5, "R6 read beats wait for data", nack, 5);
        chk(exp_r.size() == 0, "R7 all read beats", exp_r.size(), 0);

        // R4 single write at lane 2, single read at lane 3
        stall = 0;
        wbuf[0] = 8'h5A;
        exp_w.push_back({14'h0041, 8'h00, 8'h5A, 8'h00, 8'h00, 4'b0100});
        run_txn(16'h0106, 0, 0, -1, 0);
        chk(exp_w.size() == 0, "R4 single write issued", exp_w.size(), 0);
        exp_r.push_back(mem[17][31:24]);
        run_txn(16'h0047, 1, 0, -1, 0);
        chk(exp_r.size() == 0, "R4 single read returned", exp_r.size(), 0);
        chk(!cpu_perr, "R9 no error before bad parity", cpu_perr, 0);

        // R9 bad parity on a single write: flag set, data still forwarded
        wbuf[0] = 8'hC3;
        exp_w.push_back({14'h0042, 8'h00, 8'h00, 8'hC3, 8'h00, 4'b0010});
        run_txn(16'h0109, 0, 0, 0, 0);
        chk(cpu_perr, "R9 parity error flagged", cpu_perr, 1);
        chk(exp_w.size() == 0, "R9 data forwarded", exp_w.size(), 0);

        // R11 stray start during a burst write; R9 flag stays set
        for (int i = 0; i < 16; i++) wbuf[i] = 8'hA0 ^ 8'(i * 13);
        stall = 2;
        for (int w = 0; w < 4; w++)
            exp_w.push_back({14'(32 + w), wbuf[4*w+3], wbuf[4*w+2], wbuf[4*w+1], wbuf[4*w], 4'hF});
        run_txn(16'h0080, 0, 1, -1, 1);
        chk(exp_w.size() == 0, "R11 burst completed alone", exp_w.size(), 0);
        repeat (5) @(negedge clk);
        #1;
        chk(!ibus_req && !cpu_busy, "R11 no access from stray start", {ibus_req, cpu_busy}, 0);
        chk(cpu_perr, "R9 flag sticky", cpu_perr, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule